// File: doc/BRIEF.md
# Shared Memory Host Arbiter

This block decides who owns a buffer memory that a local bus master engine shares with an external host. The host asks for the memory with an asynchronous request line and is answered by one active-low acknowledge. The request is sampled on the falling clock edge and then retimed to the rising edge. If the engine is idle, the acknowledge follows almost at once. If the engine is in a transfer, the block lets that transfer finish first, which takes a fixed number of clocks plus one clock for every wait state the engine reports. While the host holds the memory, the engine is told to stay idle. When the host lets go, the engine continues.

The same acknowledge also answers host register-select requests, but by a different rule. A register grant puts the block in a slave-cycle state. The acknowledge is given only while an address strobe is at its active level, and a mode input sets the polarity of that strobe. Every register access therefore needs a new strobe pulse. A sticky flag reports a host that breaks the protocol: both requests at once, or one request following the other too closely.

Top module: `shmem_host_arbiter`

## Requirements
- R1: While `rstN` is low and right after it rises, `hostAckN` is 1 and `engineStall`, `engineHold`, `slaveCycle` and `protoErr` are 0.
- R2: A memory request captured at a falling edge while `xferActive` is 0 drives `hostAckN` low at the next falling edge, one clock later. `hostAckN` only ever changes on falling edges.
- R3: A memory request captured while `xferActive` is 1 drives `hostAckN` low LAT_BUSY (default 5) falling edges after capture, when no wait states occur. `engineStall` is 1 while the transfer is being drained.
- R4: Each rising edge during the drain at which `xferWait` is 1 delays the acknowledge by one clock.
- R5: Once granted, `hostAckN` stays low and `engineHold` stays 1 for as long as `hostMemReq` stays high.
- R6: When `hostMemReq` falls, `hostAckN` returns to 1 one falling edge after the low level is captured. `engineHold` and `engineStall` are 0 on the rising edge after that.
- R7: With `strobeActLow` = 1, a register-select request gets `hostAckN` low only while `addrStrobe` is 0.
- R8: With `strobeActLow` = 0, a register-select request gets `hostAckN` low only while `addrStrobe` is 1.
- R9: While `hostRegSel` stays high, `hostAckN` goes back to 1 whenever the strobe leaves its active level, and it goes low again on the next active strobe. `slaveCycle` stays 1 throughout.
- R10: If `hostMemReq` and `hostRegSel` are captured high together, `protoErr` is set. It stays set until reset.
- R11: `protoErr` is set if one request rises after fewer than MIN_GAP (default 2) low clocks of the other request. With MIN_GAP or more low clocks in between, `protoErr` stays 0.
- R12: `engineHold` and `slaveCycle` are never 1 at the same time.
- R13: `hostAckN` is low only if a request was present in the preceding cycle. It is 1 once both requests have been low for three consecutive rising-edge samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostMemReq | input | 1 | Asynchronous host request for the shared memory |
| hostRegSel | input | 1 | Asynchronous host register-select request |
| addrStrobe | input | 1 | Host address strobe for register accesses |
| strobeActLow | input | 1 | Strobe polarity: 1 = active low, 0 = active high |
| xferActive | input | 1 | Local engine is in a memory transfer |
| xferWait | input | 1 | Local engine is inserting a wait state this cycle |
| hostAckN | output | 1 | Active-low acknowledge to the host, updated on falling edges |
| engineStall | output | 1 | Engine must not start a new transfer (drain or hold) |
| engineHold | output | 1 | Host owns the memory; engine is held idle |
| slaveCycle | output | 1 | Block is serving a register-select slave cycle |
| protoErr | output | 1 | Sticky host protocol-violation flag |

## Verification
The memory path is driven in two ways: with the engine idle, and with the engine busy and zero to three wait states. The acknowledge edge lands on a different clock in each case, so a wrong base latency, a missed wait state or a wait state counted twice moves the edge and shows up as a mismatch. The register path is run under both strobe polarities, with the strobe toggled while the select stays high. This separates a strobe-gated acknowledge from one that follows the select alone. Request spacings of one and two clocks, in both directions, together with fully simultaneous requests, show that the error flag fires at the right threshold and then holds.

// File: rtl/shmarb_pkg.sv
package shmarb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_HOLD  = 2'd2,
    ST_SLAVE = 2'd3
  } arbState_t;

  // control -> datapath
  typedef struct packed {
    logic grant;      // acknowledge wanted at next falling edge
    logic drainLoad;  // restart the drain counter
    logic drainStep;  // drain in progress this cycle
  } ctrlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic syncMem;
    logic syncSel;
    logic stbActive;
    logic drainDone;
  } dpStatus_t;

endpackage

// File: rtl/shmarb_dp.sv
module shmarb_dp
  import shmarb_pkg::*;
#(
  parameter int LAT_BUSY = 5,
  parameter int MIN_GAP  = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostMemReq,
  input  logic         hostRegSel,
  input  logic         addrStrobe,
  input  logic         strobeActLow,
  input  logic         xferWait,
  input  ctrlStrobes_t strb,
  output dpStatus_t    stat,
  output logic         hostAckN,
  output logic         protoErr
);

  localparam int NUM_IN     = 3;
  localparam int DRAIN_LAST = LAT_BUSY - 3;
  localparam int CNT_W      = $clog2(DRAIN_LAST + 2);
  localparam int AGO_W      = $clog2(MIN_GAP + 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DRAIN_LAST);
  localparam logic [AGO_W-1:0] AGO_MAX  = AGO_W'(MIN_GAP);

  // ---------------- input capture: falling edge, then rising edge
  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] fallStage;
  logic [NUM_IN-1:0] riseStage;

  assign rawIn = {addrStrobe, hostRegSel, hostMemReq};

  for (genvar i = 0; i < NUM_IN; i++) begin : g_sync
    always_ff @(negedge clk or negedge rstN) begin
      if (!rstN) fallStage[i] <= 1'b0;
      else       fallStage[i] <= rawIn[i];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) riseStage[i] <= 1'b0;
      else       riseStage[i] <= fallStage[i];
    end
  end

  logic syncStb;
  assign syncStb = riseStage[2];

  // ---------------- drain counter for the engine's current transfer
  logic [CNT_W-1:0] drainCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drainCnt <= '0;
    end else if (strb.drainLoad) begin
      drainCnt <= '0;
    end else if (strb.drainStep && !xferWait && drainCnt != CNT_LAST) begin
      drainCnt <= drainCnt + 1'b1;
    end
  end

  // ---------------- spacing and overlap monitor (channel 0 mem, 1 sel)
  logic [1:0]       reqSync;
  logic [1:0]       reqPrev;
  logic [AGO_W-1:0] lowAgo [2];
  logic [1:0]       tooClose;

  assign reqSync = riseStage[1:0];

  for (genvar ch = 0; ch < 2; ch++) begin : g_gap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqPrev[ch] <= 1'b0;
        lowAgo[ch]  <= AGO_MAX;
      end else begin
        reqPrev[ch] <= reqSync[ch];
        if (reqSync[ch])              lowAgo[ch] <= '0;
        else if (lowAgo[ch] < AGO_MAX) lowAgo[ch] <= lowAgo[ch] + 1'b1;
      end
    end
    assign tooClose[ch] = reqSync[ch] && !reqPrev[ch] && (lowAgo[1-ch] < AGO_MAX);
  end

  logic overlapSeen;
  assign overlapSeen = reqSync[0] && reqSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          protoErr <= 1'b0;
    else if (overlapSeen || |tooClose)  protoErr <= 1'b1;
  end

  // ---------------- acknowledge register, falling edge only
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) hostAckN <= 1'b1;
    else       hostAckN <= ~strb.grant;
  end

  // ---------------- status to control
  always_comb begin
    stat.syncMem   = reqSync[0];
    stat.syncSel   = reqSync[1];
    stat.stbActive = strobeActLow ? ~syncStb : syncStb;
    stat.drainDone = (drainCnt == CNT_LAST) && !xferWait;
  end

endmodule

// File: rtl/shmarb_ctrl.sv
module shmarb_ctrl
  import shmarb_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         xferActive,
  input  dpStatus_t    stat,
  output ctrlStrobes_t strb,
  output logic         engineStall,
  output logic         engineHold,
  output logic         slaveCycle
);

  arbState_t state, stateNext;
  logic      tgtSel, tgtSelNext;
  logic      tgtReq;

  assign tgtReq = tgtSel ? stat.syncSel : stat.syncMem;

  always_comb begin
    stateNext  = state;
    tgtSelNext = tgtSel;
    unique case (state)
      ST_IDLE: begin
        if (stat.syncMem) begin
          tgtSelNext = 1'b0;
          stateNext  = xferActive ? ST_DRAIN : ST_HOLD;
        end else if (stat.syncSel) begin
          tgtSelNext = 1'b1;
          stateNext  = xferActive ? ST_DRAIN : ST_SLAVE;
        end
      end
      ST_DRAIN: begin
        if (!tgtReq)             stateNext = ST_IDLE;
        else if (stat.drainDone) stateNext = tgtSel ? ST_SLAVE : ST_HOLD;
      end
      ST_HOLD:  if (!stat.syncMem) stateNext = ST_IDLE;
      ST_SLAVE: if (!stat.syncSel) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      tgtSel <= 1'b0;
    end else begin
      state  <= stateNext;
      tgtSel <= tgtSelNext;
    end
  end

  logic idleFree, memGrant, regGrant;
  assign idleFree = (state == ST_IDLE) && !xferActive;
  assign memGrant = stat.syncMem && (idleFree || state == ST_HOLD);
  assign regGrant = stat.syncSel && stat.stbActive &&
                    ((idleFree && !stat.syncMem) || state == ST_SLAVE);

  always_comb begin
    strb.grant     = memGrant || regGrant;
    strb.drainLoad = (state == ST_IDLE) && (stateNext == ST_DRAIN);
    strb.drainStep = (state == ST_DRAIN);
  end

  assign engineStall = (state == ST_DRAIN) || (state == ST_HOLD);
  assign engineHold  = (state == ST_HOLD);
  assign slaveCycle  = (state == ST_SLAVE);

endmodule

// File: rtl/shmem_host_arbiter.sv
module shmem_host_arbiter
  import shmarb_pkg::*;
#(
  parameter int LAT_BUSY = 5,
  parameter int MIN_GAP  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic hostMemReq,
  input  logic hostRegSel,
  input  logic addrStrobe,
  input  logic strobeActLow,
  input  logic xferActive,
  input  logic xferWait,
  output logic hostAckN,
  output logic engineStall,
  output logic engineHold,
  output logic slaveCycle,
  output logic protoErr
);

  ctrlStrobes_t strb;
  dpStatus_t    stat;

  shmarb_dp #(
    .LAT_BUSY(LAT_BUSY),
    .MIN_GAP (MIN_GAP)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .hostMemReq  (hostMemReq),
    .hostRegSel  (hostRegSel),
    .addrStrobe  (addrStrobe),
    .strobeActLow(strobeActLow),
    .xferWait    (xferWait),
    .strb        (strb),
    .stat        (stat),
    .hostAckN    (hostAckN),
    .protoErr    (protoErr)
  );

  shmarb_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .xferActive (xferActive),
    .stat       (stat),
    .strb       (strb),
    .engineStall(engineStall),
    .engineHold (engineHold),
    .slaveCycle (slaveCycle)
  );

endmodule

// File: rtl/shmarb_chk.sv
module shmarb_chk (
  input logic clk,
  input logic rstN,
  input logic hostMemReq,
  input logic hostRegSel,
  input logic hostAckN,
  input logic engineHold,
  input logic slaveCycle,
  input logic protoErr
);

  // R12
  hold_slave_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(engineHold && slaveCycle));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  // R10
  overlap_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostMemReq && hostRegSel) |=> ##1 protoErr);

  // R13
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hostAckN |-> ($past(hostMemReq) || $past(hostRegSel)));

  // R13
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hostMemReq && !hostRegSel && $past(!hostMemReq && !hostRegSel)
     && $past(!hostMemReq && !hostRegSel, 2)) |-> hostAckN);

endmodule

bind shmem_host_arbiter shmarb_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostMemReq(hostMemReq),
  .hostRegSel(hostRegSel),
  .hostAckN  (hostAckN),
  .engineHold(engineHold),
  .slaveCycle(slaveCycle),
  .protoErr  (protoErr)
);

// File: tb/sim_shmem_host_arbiter.sv
`timescale 1ns/1ps
module sim_shmem_host_arbiter;

  logic clk = 1'b0;
  logic rstN;
  logic hostMemReq, hostRegSel, addrStrobe, strobeActLow, xferActive, xferWait;
  logic hostAckN, engineStall, engineHold, slaveCycle, protoErr;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  always #2.5 clk = ~clk;

  shmem_host_arbiter u0 (
    .clk(clk), .rstN(rstN), .hostMemReq(hostMemReq), .hostRegSel(hostRegSel),
    .addrStrobe(addrStrobe), .strobeActLow(strobeActLow), .xferActive(xferActive),
    .xferWait(xferWait), .hostAckN(hostAckN), .engineStall(engineStall),
    .engineHold(engineHold), .slaveCycle(slaveCycle), .protoErr(protoErr)
  );

  // memory-latency vectors: busy, wait states, tick of first low acknowledge
  typedef struct packed {
    logic       busy;
    logic [2:0] waits;
    logic [3:0] lowAt;
  } vec_t;
  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{busy:1'b0, waits:3'd0, lowAt:4'd2},
    '{busy:1'b1, waits:3'd0, lowAt:4'd6},
    '{busy:1'b1, waits:3'd1, lowAt:4'd7},
    '{busy:1'b1, waits:3'd3, lowAt:4'd9},
    '{busy:1'b1, waits:3'd2, lowAt:4'd8}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    hostMemReq = 0; hostRegSel = 0; addrStrobe = 0; strobeActLow = 1;
    xferActive = 0; xferWait = 0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    doReset();
    // R1 reset state
    chk("R1 ack", hostAckN, 1);
    chk("R1 stall", engineStall, 0);
    chk("R1 hold", engineHold, 0);
    chk("R1 slave", slaveCycle, 0);
    chk("R1 err", protoErr, 0);

    // memory path table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      xferActive = VECS[i].busy;
      xferWait   = 0;
      tick(); tick();
      hostMemReq = 1;
      for (int k = 1; k <= int'(VECS[i].lowAt); k++) begin
        tick();
        xferWait = VECS[i].busy && k >= 2 && k <= 1 + int'(VECS[i].waits);
        if (VECS[i].busy && k == 2) begin
          chk("R3 stall during drain", engineStall, 1);
          chk("R3 ack during drain", hostAckN, 1);
        end
        if (k == int'(VECS[i].lowAt) - 1)
          chk(VECS[i].busy ? "R4 ack not yet" : "R2 ack not yet", hostAckN, 1);
        if (k == int'(VECS[i].lowAt)) begin
          chk(VECS[i].busy ? "R3 R4 ack latency" : "R2 ack latency", hostAckN, 0);
          chk("R5 hold on grant", engineHold, 1);
        end
      end
      xferActive = 0;
      xferWait   = 0;
      repeat (3) tick();
      chk("R5 ack held", hostAckN, 0);
      chk("R12 no slave in hold", slaveCycle, 0);
      hostMemReq = 0;
      tick(); tick();
      chk("R6 ack released", hostAckN, 1);
      chk("R6 hold released", engineHold, 0);
      chk("R6 stall released", engineStall, 0);
      tick();
    end

    // R7 R9: register path, strobe active low
    strobeActLow = 1; addrStrobe = 1;
    tick();
    hostRegSel = 1;
    tick(); tick();
    chk("R7 no ack without strobe", hostAckN, 1);
    chk("R9 slave cycle", slaveCycle, 1);
    addrStrobe = 0;
    tick();
    chk("R7 ack not yet", hostAckN, 1);
    tick();
    chk("R7 ack on low strobe", hostAckN, 0);
    tick();
    addrStrobe = 1;
    tick(); tick();
    chk("R9 ack released by strobe", hostAckN, 1);
    chk("R9 slave kept", slaveCycle, 1);
    addrStrobe = 0;
    tick(); tick();
    chk("R9 fresh strobe ack", hostAckN, 0);
    hostRegSel = 0; addrStrobe = 1;
    tick(); tick();
    chk("R13 ack idle after select", hostAckN, 1);
    chk("R9 slave ended", slaveCycle, 0);
    repeat (3) tick();

    // R8: register path, strobe active high
    strobeActLow = 0; addrStrobe = 0;
    tick();
    hostRegSel = 1;
    tick(); tick();
    chk("R8 no ack on low strobe", hostAckN, 1);
    chk("R12 no hold in slave", engineHold, 0);
    addrStrobe = 1;
    tick(); tick();
    chk("R8 ack on high strobe", hostAckN, 0);
    addrStrobe = 0;
    tick(); tick();
    chk("R8 ack released", hostAckN, 1);
    hostRegSel = 0;
    repeat (4) tick();
    chk("R11 no error so far", protoErr, 0);

    // R11: two low clocks between requests is legal
    hostMemReq = 1;
    repeat (4) tick();
    hostMemReq = 0;
    tick(); tick();
    hostRegSel = 1;
    repeat (5) tick();
    chk("R11 gap of two legal", protoErr, 0);
    hostRegSel = 0;
    repeat (4) tick();

    // R11: one low clock, memory then select
    doReset();
    hostMemReq = 1;
    repeat (4) tick();
    hostMemReq = 0;
    tick();
    hostRegSel = 1;
    repeat (4) tick();
    chk("R11 gap of one mem->sel", protoErr, 1);
    hostRegSel = 0;

    // R11: one low clock, select then memory
    doReset();
    chk("R10 err cleared by reset", protoErr, 0);
    hostRegSel = 1;
    repeat (4) tick();
    hostRegSel = 0;
    tick();
    hostMemReq = 1;
    repeat (4) tick();
    chk("R11 gap of one sel->mem", protoErr, 1);
    hostMemReq = 0;

    // R10: simultaneous requests, sticky flag
    doReset();
    hostMemReq = 1; hostRegSel = 1;
    repeat (4) tick();
    chk("R10 overlap flagged", protoErr, 1);
    hostMemReq = 0; hostRegSel = 0;
    repeat (6) tick();
    chk("R10 flag sticky", protoErr, 1);
    chk("R13 ack idle", hostAckN, 1);

    report();
  end

endmodule